// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block carries out one maintenance command over a run of cache lines. Software loads a start address, then an end address, through two writes on a small register port. The second write launches the command. The engine then walks every 32-byte line whose first byte address is no lower than the start and no higher than the end, both bounds included. It presents one line per cycle on a valid/ready line-operation port, and the cache behind that port performs the requested action.

While a command runs, a stall output stays high so that the processor pipeline waits. A one-cycle done pulse marks the release. A command whose two bounds lie in different 4 KiB pages is refused with a one-cycle error pulse, and no line is issued. A third write kind issues a single-line action directly.

On the line port, a line is handed over in any cycle where `line_valid` and `line_ready` are both high. While `line_ready` is low, the engine keeps `line_valid` high and holds `line_addr` and `line_act` unchanged. The receiver may hold `line_ready` low for as long as it needs, and the stall is simply extended.

Top module: `range_maint_engine`

## Requirements
- R1: A write with `reg_sel`=0 records the start address and the action. A later write with `reg_sel`=1 carries the end address and launches the command. `stall` is high in the cycle after that end write.
- R2: A launched range issues, in ascending order and each exactly once, every address that is a multiple of 32 and lies within start..end inclusive. The first address is the start rounded up to a line boundary. Each line carries the action recorded with the start write. Action codes are 0 = clean, 1 = invalidate and 2 = clean-and-invalidate.
- R3: While `line_valid` is high and `line_ready` is low, the next cycle still shows `line_valid` high with the same `line_addr` and `line_act`.
- R4: `stall` stays high from the cycle after launch through the cycle of the last handshake. With `line_ready` held high, an N-line command stalls for exactly N cycles. `done` pulses for one cycle, in the first cycle that `stall` is low.
- R5: If the start and end addresses differ in any bit at or above bit 12, `err` pulses for one cycle. No line is issued, `stall` stays low, and the start must be written again.
- R6: If no line start lies in the range (start above end, or start rounded up passing end), the command issues no line, stalls for one cycle and pulses `done`.
- R7: An end write that has no recorded start before it is ignored: no stall, no line, no error. Each launch or error consumes the recorded start.
- R8: A write with `reg_sel`=2 issues one line at its address rounded down to 32 bytes, using the action in that write. With `line_ready` high, it stalls for one cycle.
- R9: Register writes that arrive while `stall` is high are ignored. They record no start and launch nothing.
- R10: After reset, `stall`, `done`, `err` and `line_valid` are low and no start is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write kind: 0 start, 1 end, 2 single line, 3 ignored |
| reg_act | input | 2 | Action code for start or single-line writes |
| reg_addr | input | ADDR_W | Address written |
| stall | output | 1 | High while a command is running |
| done | output | 1 | One-cycle pulse when the stall is released |
| err | output | 1 | One-cycle pulse on a page-crossing command |
| line_valid | output | 1 | A line operation is offered |
| line_ready | input | 1 | Receiver accepts the offered line |
| line_addr | output | ADDR_W | First byte address of the offered line |
| line_act | output | 2 | Action for the offered line |

## Verification
A corrupted line counter shows up at the line port in the very next handshake, as a wrong, missing or repeated address in the stream the scoreboard expects. A bad end bound appears as an extra or missing final line and a stall length that is one cycle off. A stuck recorded-start flag shows within a few cycles of a lone end write or a write made during a stall, as an unexpected stall, line or error pulse. Random back-pressure on `line_ready` exposes any address or action that changes while a line is waiting.

// File: rtl/rme_pkg.sv
`timescale 1ns/1ps
package rme_pkg;
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_END    = 2'd1,
    SEL_SINGLE = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_CLEAN     = 2'd0,
    ACT_INV       = 2'd1,
    ACT_CLEAN_INV = 2'd2,
    ACT_RSVD      = 2'd3
  } line_act_e;
endpackage

// File: rtl/rme_launch.sv
`timescale 1ns/1ps
module rme_launch
  import rme_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        reg_act,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              busy,
  output logic              launch,
  output logic [ADDR_W:0]   first,
  output logic [ADDR_W:0]   last,
  output logic [1:0]        act,
  output logic              err
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int CW   = ADDR_W + 1;

  logic              armed;
  logic [ADDR_W-1:0] start_q;
  logic [1:0]        act_q;
  logic              err_q;

  logic accept, is_start, is_end, is_single, page_diff, range_go, range_bad;
  logic [CW-1:0] start_up, single_dn;

  always_comb begin
    accept    = reg_we && !busy;
    is_start  = accept && (reg_sel == SEL_START);
    is_end    = accept && (reg_sel == SEL_END);
    is_single = accept && (reg_sel == SEL_SINGLE);
    page_diff = start_q[ADDR_W-1:PG_W] != reg_addr[ADDR_W-1:PG_W];
    range_go  = is_end && armed && !page_diff;
    range_bad = is_end && armed && page_diff;
    start_up  = ({1'b0, start_q} + CW'(LINE_BYTES - 1)) & ~CW'(LINE_BYTES - 1);
    single_dn = {1'b0, reg_addr & ~ADDR_W'(LINE_BYTES - 1)};
    launch    = range_go || is_single;
    first     = is_single ? single_dn : start_up;
    last      = is_single ? single_dn : {1'b0, reg_addr};
    act       = is_single ? reg_act : act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      start_q <= '0;
      act_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= range_bad;
      if (is_start) begin
        armed   <= 1'b1;
        start_q <= reg_addr;
        act_q   <= reg_act;
      end else if (is_end || is_single) begin
        armed <= 1'b0;
      end
    end
  end

  assign err = err_q;

  // R5: a refused command never starts the walker
  a_r5_err_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R9: nothing launches while a command is running
  a_r9_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

// File: rtl/rme_walker.sv
`timescale 1ns/1ps
module rme_walker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W:0]   first,
  input  logic [ADDR_W:0]   last,
  input  logic [1:0]        act_in,
  input  logic              line_ready,
  output logic              busy,
  output logic              done,
  output logic              line_valid,
  output logic [ADDR_W-1:0] line_addr,
  output logic [1:0]        line_act
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CW    = ADDR_W + 1;

  logic [CW-1:0] cur, last_q, nxt;
  logic [1:0]    act_q;

  always_comb begin
    line_valid = busy && (cur <= last_q);
    nxt        = cur + CW'(LINE_BYTES);
    line_addr  = cur[ADDR_W-1:0];
    line_act   = act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cur    <= '0;
      last_q <= '0;
      act_q  <= '0;
    end else begin
      done <= 1'b0;
      if (launch && !busy) begin
        busy   <= 1'b1;
        cur    <= first;
        last_q <= last;
        act_q  <= act_in;
      end else if (busy) begin
        if (!line_valid) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (line_ready) begin
          cur <= nxt;
          if (nxt > last_q) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  // R3: an offered line is held until taken
  a_r3_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |=> line_valid && $stable(line_addr) && $stable(line_act));
  // R4: done marks the release of the stall
  a_r4_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2: offered addresses are line aligned
  a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (line_addr[OFF_W-1:0] == '0));
endmodule

// File: rtl/range_maint_engine.sv
`timescale 1ns/1ps
module range_maint_engine #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        reg_act,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              stall,
  output logic              done,
  output logic              err,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [ADDR_W-1:0] line_addr,
  output logic [1:0]        line_act
);
  logic            busy, launch;
  logic [ADDR_W:0] first, last;
  logic [1:0]      act;

  rme_launch #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_launch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_act(reg_act),
    .reg_addr(reg_addr), .busy(busy), .launch(launch), .first(first), .last(last),
    .act(act), .err(err)
  );

  rme_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walker (
    .clk(clk), .rst_n(rst_n), .launch(launch), .first(first), .last(last),
    .act_in(act), .line_ready(line_ready), .busy(busy), .done(done),
    .line_valid(line_valid), .line_addr(line_addr), .line_act(line_act)
  );

  assign stall = busy;

  // R1: a launching end write raises the stall on the next cycle
  a_r1_stall_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stall);
  // R5: an error pulse never coincides with a line offer
  a_r5_err_no_line: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !line_valid);
endmodule

// File: tb/range_maint_engine_test.sv
`timescale 1ns/1ps
module range_maint_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [1:0]  reg_act = 2'd0;
  logic [31:0] reg_addr = 32'd0;
  logic        line_ready = 1'b0;
  logic        stall, done, err, line_valid;
  logic [31:0] line_addr;
  logic [1:0]  line_act;

  always #2 clk = ~clk;

  range_maint_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_act(reg_act),
    .reg_addr(reg_addr), .stall(stall), .done(done), .err(err),
    .line_valid(line_valid), .line_ready(line_ready), .line_addr(line_addr),
    .line_act(line_act)
  );

  int errors = 0, checks = 0;
  int done_cnt = 0, err_cnt = 0, stall_cyc = 0;
  int ready_mode = 1;
  logic [15:0] lfsr = 16'hACE1;
  logic [33:0] exp_q[$];
  logic        hold_pend = 1'b0;
  logic [33:0] hold_val;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0:       line_ready = 1'b0;
      1:       line_ready = 1'b1;
      default: line_ready = lfsr[0];
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall) stall_cyc++;
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (hold_pend)
        chk(line_valid && ({line_act, line_addr} == hold_val), "R3", "held line",
            {line_valid, line_act, line_addr}, {1'b1, hold_val});
      hold_pend = line_valid && !line_ready;
      hold_val  = {line_act, line_addr};
      if (line_valid && line_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected line", {line_act, line_addr}, 0);
        end else begin
          logic [33:0] e;
          e = exp_q.pop_front();
          chk(e == {line_act, line_addr}, "R2", "line", {line_act, line_addr}, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [1:0] act, input logic [31:0] addr);
    reg_we = 1'b1; reg_sel = sel; reg_act = act; reg_addr = addr;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int t = 0; t < 5000 && done_cnt == d0; t++) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  task automatic run_range(input logic [31:0] s, input logic [31:0] e,
                           input logic [1:0] act, input bit len_chk);
    int n, sc0, d0, e0;
    bit bad;
    bad = (s[31:12] != e[31:12]);
    if (!bad)
      for (longint a = (longint'(s) + 31) & ~longint'(31); a <= longint'(e); a += 32)
        exp_q.push_back({act, a[31:0]});
    n = exp_q.size();
    sc0 = stall_cyc; d0 = done_cnt; e0 = err_cnt;
    wr(2'd0, act, s);
    wr(2'd1, 2'd0, e);
    if (bad) begin
      repeat (4) @(posedge clk);
      #1;
      chk(err_cnt - e0 == 1, "R5", "error pulses", err_cnt - e0, 1);
      chk(stall_cyc == sc0, "R5", "stall cycles", stall_cyc - sc0, 0);
      chk(done_cnt == d0, "R5", "done pulses", done_cnt - d0, 0);
    end else begin
      chk(stall == 1'b1, "R1", "stall after end write", stall, 1);
      wait_done(d0);
      chk(done_cnt - d0 == 1, "R4", "done pulses", done_cnt - d0, 1);
      chk(exp_q.size() == 0, "R2", "lines left", exp_q.size(), 0);
      chk(err_cnt == e0, "R5", "no error", err_cnt - e0, 0);
      if (len_chk)
        chk(stall_cyc - sc0 == ((n == 0) ? 1 : n), (n == 0) ? "R6" : "R4",
            "stall length", stall_cyc - sc0, (n == 0) ? 1 : n);
    end
  endtask

  task automatic run_single(input logic [31:0] addr, input logic [1:0] act);
    int sc0, d0;
    exp_q.push_back({act, addr & 32'hFFFF_FFE0});
    sc0 = stall_cyc; d0 = done_cnt;
    wr(2'd2, act, addr);
    chk(stall == 1'b1, "R8", "single stall", stall, 1);
    wait_done(d0);
    chk(exp_q.size() == 0, "R8", "single line issued", exp_q.size(), 0);
    chk(stall_cyc - sc0 == 1, "R8", "single stall length", stall_cyc - sc0, 1);
  endtask

  task automatic quiet_check(input string req, input int cycles);
    int sc0, e0, d0;
    sc0 = stall_cyc; e0 = err_cnt; d0 = done_cnt;
    repeat (cycles) @(posedge clk);
    #1;
    chk(stall_cyc == sc0 && err_cnt == e0 && done_cnt == d0, req, "no activity",
        (stall_cyc - sc0) + (err_cnt - e0) + (done_cnt - d0), 0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    chk(!stall && !done && !err && !line_valid, "R10", "reset outputs",
        {stall, done, err, line_valid}, 0);
    // R7 / R10: no start recorded after reset
    wr(2'd1, 2'd0, 32'h0000_01FF);
    quiet_check("R7", 5);

    ready_mode = 1;
    run_range(32'h0000_1000, 32'h0000_10FF, 2'd0, 1'b1);   // 8 lines
    run_range(32'h0000_2005, 32'h0000_2060, 2'd1, 1'b1);   // unaligned start, 3 lines
    run_range(32'h0000_9FE0, 32'h0000_9FFF, 2'd2, 1'b1);   // last line of page
    run_range(32'h0000_4001, 32'h0000_401F, 2'd0, 1'b1);   // R6 rounding passes end
    run_range(32'h0000_5100, 32'h0000_5000, 2'd1, 1'b1);   // R6 start above end
    run_range(32'h0000_6FE0, 32'h0000_7000, 2'd0, 1'b0);   // R5 page crossing
    // R5 / R7: the refused start is consumed
    wr(2'd1, 2'd0, 32'h0000_6FFF);
    quiet_check("R7", 5);
    run_single(32'h0000_80A7, 2'd1);                       // R8
    run_single(32'h0000_C01F, 2'd2);                       // R8

    ready_mode = 2;
    run_range(32'h0000_3000, 32'h0000_33FF, 2'd2, 1'b0);   // back-pressure, 32 lines

    // R9: writes during a stall are ignored
    begin
      int d0, e0;
      ready_mode = 0;
      for (longint a = 32'hA000; a <= 32'hA0FF; a += 32)
        exp_q.push_back({2'd0, a[31:0]});
      d0 = done_cnt; e0 = err_cnt;
      wr(2'd0, 2'd0, 32'h0000_A000);
      wr(2'd1, 2'd0, 32'h0000_A0FF);
      wr(2'd0, 2'd1, 32'h0000_B000);
      wr(2'd1, 2'd0, 32'h0000_C0FF);
      wr(2'd2, 2'd1, 32'h0000_B040);
      chk(err_cnt == e0, "R9", "no error during stall", err_cnt - e0, 0);
      ready_mode = 2;
      wait_done(d0);
      chk(exp_q.size() == 0, "R9", "only first range issued", exp_q.size(), 0);
      chk(done_cnt - d0 == 1, "R9", "one done", done_cnt - d0, 1);
      wr(2'd1, 2'd0, 32'h0000_B0FF);
      quiet_check("R9", 6);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule